// File: doc/BRIEF.md
# Indexed Addressing Effective-Address Unit

This unit turns the one-byte postbyte of an indexed memory operand into an effective address. From the postbyte it picks one of four 16-bit pointer registers as the base, or the program counter. It forms the address from a short embedded offset, an accumulator, or constant bytes taken from the instruction stream. For auto-increment and auto-decrement forms it returns the updated pointer value, and for every form it reports the extra clock cycles that form costs and how many stream bytes it consumed.

When the postbyte requests indirection, the address computed first is used as a pointer. The unit reads a big-endian word there over a byte-wide read port with one cycle of latency, and that word becomes the effective address. The surrounding sequencer pulses `start` with all operands valid. The results appear with a one-cycle `done` pulse and stay on the outputs until the next accepted request.

Top module: `idx_ea_unit`

## Requirements
- R1: Postbyte bits 6:5 pick the base pointer (0 = X, 1 = Y, 2 = U, 3 = S), and `wb_sel` reports that same code.
- R2: With postbyte bit 7 clear, the address is the base plus the sign-extended bits 4:0 (bit 4 is the sign). The form costs 1 extra cycle and consumes 0 bytes.
- R3: With bit 7 set, sub-modes (bits 3:0) 0/1 return the old base as the address and write back base+1/base+2. Sub-modes 2/3 write back base-1/base-2 and return that new value. `wb_en` is high only in the `done` cycle of these forms.
- R4: Sub-modes 5 and 6 add the sign-extended B or A accumulator. Sub-mode 11 adds the 16-bit value with A as the high byte and B as the low byte. Sub-mode 4 adds nothing.
- R5: Sub-mode 8 adds the sign-extended first stream byte (1 byte consumed). Sub-mode 9 adds the 16-bit stream value, high byte first (2 bytes consumed).
- R6: Sub-modes 12 and 13 ignore the base bits. They add the 8-bit signed or 16-bit stream offset to `pc_next` plus the number of offset bytes consumed.
- R7: Extra cycles for direct forms (bit 4 clear) by sub-mode: 0:2, 1:3, 2:2, 3:3, 4:0, 5:1, 6:1, 8:1, 9:4, 11:4, 12:1, 13:5.
- R8: With bit 4 set, two reads go to the computed pointer and pointer+1. The effective address is the word read, with the first byte as the high half. Extra cycles: 1:6, 3:6, 4:3, 5:4, 6:4, 8:4, 9:7, 11:7, 12:4, 13:8, 15:5.
- R9: Indirect sub-mode 15 takes the pointer directly from the two stream bytes (2 bytes consumed).
- R10: Undefined forms (sub-modes 7, 10 and 14, sub-modes 0 and 2 when indirect, and 15 when direct) give address 0, 0 cycles, 0 bytes, no write-back and no memory read.
- R11: `done` follows an accepted `start` by 1 cycle for direct forms and 4 cycles for indirect forms. `busy` is high in between, and `start` is ignored while `busy` is high.
- R12: `done` is a single-cycle pulse, and all result outputs hold their values until the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, operands valid |
| postbyte | input | 8 | Indexed-mode postbyte |
| reg_x | input | ADDR_W | Pointer X |
| reg_y | input | ADDR_W | Pointer Y |
| reg_u | input | ADDR_W | Pointer U |
| reg_s | input | ADDR_W | Pointer S |
| acc_a | input | BYTE_W | Accumulator A |
| acc_b | input | BYTE_W | Accumulator B |
| pc_next | input | ADDR_W | Address of the byte after the postbyte |
| ext_hi | input | BYTE_W | First stream byte after the postbyte |
| ext_lo | input | BYTE_W | Second stream byte after the postbyte |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | ADDR_W | Memory read address |
| mem_rd_data | input | BYTE_W | Read data, valid the cycle after the strobe |
| busy | output | 1 | Indirect pointer fetch in progress |
| done | output | 1 | Result valid pulse |
| ea | output | ADDR_W | Effective address |
| wb_en | output | 1 | Pointer write-back strobe |
| wb_sel | output | 2 | Pointer written back (base code) |
| wb_data | output | ADDR_W | New pointer value |
| extra_cyc | output | CYC_W | Extra clock cycles of the form |
| bytes_used | output | 2 | Stream bytes consumed |

## Verification
The embedded assertions check the handshake and read-port rules on every cycle. They cover these points:
- `done` is a single-cycle pulse.
- Write-back only coincides with `done`.
- Reads occur only while busy, at consecutive addresses.
- A fetch starts the cycle after acceptance.
- Undefined forms leave address and cycle count at zero.
- Captured results stay stable while a request is being ignored.

The arithmetic of each form can only be shown by the directed scenarios, which compare against hand-derived values. That arithmetic covers signed offsets, accumulator and D offsets, PC advance, pre/post update values, the per-form cycle tables, big-endian word assembly and the latency in cycles.

// File: rtl/idx_ea_pkg.sv
package idx_ea_pkg;

   typedef enum logic [1:0] {
      BASE_X = 2'd0,
      BASE_Y = 2'd1,
      BASE_U = 2'd2,
      BASE_S = 2'd3
   } base_e;

   localparam logic [3:0] SM_INC1 = 4'd0;
   localparam logic [3:0] SM_INC2 = 4'd1;
   localparam logic [3:0] SM_DEC1 = 4'd2;
   localparam logic [3:0] SM_DEC2 = 4'd3;
   localparam logic [3:0] SM_ZERO = 4'd4;
   localparam logic [3:0] SM_ACCB = 4'd5;
   localparam logic [3:0] SM_ACCA = 4'd6;
   localparam logic [3:0] SM_OFF8 = 4'd8;
   localparam logic [3:0] SM_OFF16 = 4'd9;
   localparam logic [3:0] SM_ACCD = 4'd11;
   localparam logic [3:0] SM_PC8 = 4'd12;
   localparam logic [3:0] SM_PC16 = 4'd13;
   localparam logic [3:0] SM_ABS = 4'd15;

   typedef struct packed {
      logic       legal;
      logic       short_form;
      logic       indirect;
      base_e      base;
      logic [3:0] sub;
      logic [1:0] nbytes;
      logic [3:0] cycles;
   } mode_t;

   function automatic logic form_legal(input logic ind, input logic [3:0] sub);
      case (sub)
         SM_INC2, SM_DEC2, SM_ZERO, SM_ACCB, SM_ACCA,
         SM_OFF8, SM_OFF16, SM_ACCD, SM_PC8, SM_PC16: form_legal = 1'b1;
         SM_INC1, SM_DEC1:                             form_legal = !ind;
         SM_ABS:                                       form_legal = ind;
         default:                                      form_legal = 1'b0;
      endcase
   endfunction

   function automatic logic [3:0] form_cycles(input logic ind, input logic [3:0] sub);
      logic [3:0] c;
      case (sub)
         SM_INC1:  c = 4'd2;
         SM_INC2:  c = 4'd3;
         SM_DEC1:  c = 4'd2;
         SM_DEC2:  c = 4'd3;
         SM_ZERO:  c = 4'd0;
         SM_ACCB:  c = 4'd1;
         SM_ACCA:  c = 4'd1;
         SM_OFF8:  c = 4'd1;
         SM_OFF16: c = 4'd4;
         SM_ACCD:  c = 4'd4;
         SM_PC8:   c = 4'd1;
         SM_PC16:  c = 4'd5;
         SM_ABS:   c = 4'd2;
         default:  c = 4'd0;
      endcase
      // Indirection adds a fixed 3 cycles to every legal form
      if (!form_legal(ind, sub))
         form_cycles = 4'd0;
      else if (ind)
         form_cycles = c + 4'd3;
      else
         form_cycles = c;
   endfunction

   function automatic logic [1:0] form_bytes(input logic [3:0] sub);
      case (sub)
         SM_OFF8, SM_PC8:           form_bytes = 2'd1;
         SM_OFF16, SM_PC16, SM_ABS: form_bytes = 2'd2;
         default:                   form_bytes = 2'd0;
      endcase
   endfunction

endpackage

// File: rtl/idx_ea_mode_dec.sv
module idx_ea_mode_dec
   import idx_ea_pkg::*;
(
   input  logic [7:0] postbyte,
   output mode_t      mode
);

   logic       is_short;
   logic       ind;
   logic [3:0] sub;
   logic       legal;

   assign is_short = !postbyte[7];
   assign ind      = postbyte[7] && postbyte[4];
   assign sub      = postbyte[3:0];
   assign legal    = is_short || form_legal(ind, sub);

   always_comb begin
      mode.legal      = legal;
      mode.short_form = is_short;
      mode.indirect   = ind && legal;
      mode.base       = base_e'(postbyte[6:5]);
      mode.sub        = sub;
      if (is_short) begin
         mode.nbytes = 2'd0;
         mode.cycles = 4'd1;
      end else if (legal) begin
         mode.nbytes = form_bytes(sub);
         mode.cycles = form_cycles(ind, sub);
      end else begin
         mode.nbytes = 2'd0;
         mode.cycles = 4'd0;
      end
   end

   // R2
   always_comb begin
      short_cyc_chk: assert (!is_short || (mode.cycles == 4'd1 && mode.nbytes == 2'd0));
   end

   // R10
   always_comb begin
      undef_cost_chk: assert (legal || (mode.cycles == 4'd0 && mode.nbytes == 2'd0 && !mode.indirect));
   end

endmodule

// File: rtl/idx_ea_addr_gen.sv
module idx_ea_addr_gen
   import idx_ea_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int BYTE_W = 8
) (
   input  mode_t              mode,
   input  logic [4:0]         short_off,
   input  logic [ADDR_W-1:0]  reg_x,
   input  logic [ADDR_W-1:0]  reg_y,
   input  logic [ADDR_W-1:0]  reg_u,
   input  logic [ADDR_W-1:0]  reg_s,
   input  logic [BYTE_W-1:0]  acc_a,
   input  logic [BYTE_W-1:0]  acc_b,
   input  logic [ADDR_W-1:0]  pc_next,
   input  logic [BYTE_W-1:0]  ext_hi,
   input  logic [BYTE_W-1:0]  ext_lo,
   output logic [ADDR_W-1:0]  target,
   output logic               upd_en,
   output logic [ADDR_W-1:0]  upd_val
);

   localparam int XW = ADDR_W - BYTE_W;

   logic [ADDR_W-1:0] base_val;
   logic [ADDR_W-1:0] off5;
   logic [ADDR_W-1:0] sx_a;
   logic [ADDR_W-1:0] sx_b;
   logic [ADDR_W-1:0] sx_e;
   logic [ADDR_W-1:0] ext16;
   logic [ADDR_W-1:0] acc_d;
   logic [ADDR_W-1:0] pc_adv;

   always_comb begin
      case (mode.base)
         BASE_X:  base_val = reg_x;
         BASE_Y:  base_val = reg_y;
         BASE_U:  base_val = reg_u;
         default: base_val = reg_s;
      endcase
   end

   assign off5   = {{(ADDR_W-5){short_off[4]}}, short_off};
   assign sx_a   = {{XW{acc_a[BYTE_W-1]}}, acc_a};
   assign sx_b   = {{XW{acc_b[BYTE_W-1]}}, acc_b};
   assign sx_e   = {{XW{ext_hi[BYTE_W-1]}}, ext_hi};
   assign ext16  = {ext_hi, ext_lo};
   assign acc_d  = {acc_a, acc_b};
   assign pc_adv = pc_next + ADDR_W'(mode.nbytes);

   always_comb begin
      target  = '0;
      upd_en  = 1'b0;
      upd_val = base_val;
      if (mode.legal) begin
         if (mode.short_form) begin
            target = base_val + off5;
         end else begin
            case (mode.sub)
               SM_INC1: begin
                  target  = base_val;
                  upd_en  = 1'b1;
                  upd_val = base_val + ADDR_W'(1);
               end
               SM_INC2: begin
                  target  = base_val;
                  upd_en  = 1'b1;
                  upd_val = base_val + ADDR_W'(2);
               end
               SM_DEC1: begin
                  upd_en  = 1'b1;
                  upd_val = base_val - ADDR_W'(1);
                  target  = base_val - ADDR_W'(1);
               end
               SM_DEC2: begin
                  upd_en  = 1'b1;
                  upd_val = base_val - ADDR_W'(2);
                  target  = base_val - ADDR_W'(2);
               end
               SM_ZERO:  target = base_val;
               SM_ACCB:  target = base_val + sx_b;
               SM_ACCA:  target = base_val + sx_a;
               SM_OFF8:  target = base_val + sx_e;
               SM_OFF16: target = base_val + ext16;
               SM_ACCD:  target = base_val + acc_d;
               SM_PC8:   target = pc_adv + sx_e;
               SM_PC16:  target = pc_adv + ext16;
               SM_ABS:   target = ext16;
               default:  target = '0;
            endcase
         end
      end
   end

   // R3
   always_comb begin
      upd_legal_chk: assert (!upd_en || (mode.legal && !mode.short_form && mode.sub[3:2] == 2'b00));
   end

endmodule

// File: rtl/idx_ea_ptr_fetch.sv
module idx_ea_ptr_fetch #(
   parameter int ADDR_W = 16,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic [ADDR_W-1:0] ptr,
   input  logic [BYTE_W-1:0] mem_rd_data,
   output logic              busy,
   output logic              mem_rd_en,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [ADDR_W-1:0] word,
   output logic              word_valid
);

   localparam int NB = ADDR_W / BYTE_W;
   localparam int CW = $clog2(NB + 1);

   logic              busy_q;
   logic [CW-1:0]     cnt_q;
   logic [ADDR_W-1:0] ptr_q;
   logic [ADDR_W-1:0] word_q;
   logic [ADDR_W-1:0] word_nx;
   logic              last;

   assign last       = busy_q && (cnt_q == CW'(NB));
   assign mem_rd_en  = busy_q && (cnt_q < CW'(NB));
   assign mem_addr   = ptr_q + ADDR_W'(cnt_q);
   assign busy       = busy_q;
   assign word_valid = last;
   assign word       = word_nx;

   generate
      if (NB == 1) begin : g_single
         assign word_nx = mem_rd_data;
      end else begin : g_shift
         assign word_nx = {word_q[ADDR_W-BYTE_W-1:0], mem_rd_data};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
         ptr_q  <= '0;
      end else if (go && !busy_q) begin
         busy_q <= 1'b1;
         cnt_q  <= '0;
         ptr_q  <= ptr;
      end else if (busy_q) begin
         cnt_q <= cnt_q + CW'(1);
         if (last)
            busy_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         word_q <= '0;
      else if (busy_q && cnt_q != '0)
         word_q <= word_nx;
   end

   // R8
   rd_addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_en && cnt_q != '0) |-> (mem_addr == $past(mem_addr) + ADDR_W'(1)));

   // R11
   fetch_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (go && !busy_q) |=> (busy && mem_rd_en));

endmodule

// File: rtl/idx_ea_unit.sv
module idx_ea_unit
   import idx_ea_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int BYTE_W = 8,
   parameter int CYC_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [7:0]        postbyte,
   input  logic [ADDR_W-1:0] reg_x,
   input  logic [ADDR_W-1:0] reg_y,
   input  logic [ADDR_W-1:0] reg_u,
   input  logic [ADDR_W-1:0] reg_s,
   input  logic [BYTE_W-1:0] acc_a,
   input  logic [BYTE_W-1:0] acc_b,
   input  logic [ADDR_W-1:0] pc_next,
   input  logic [BYTE_W-1:0] ext_hi,
   input  logic [BYTE_W-1:0] ext_lo,
   output logic              mem_rd_en,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [BYTE_W-1:0] mem_rd_data,
   output logic              busy,
   output logic              done,
   output logic [ADDR_W-1:0] ea,
   output logic              wb_en,
   output logic [1:0]        wb_sel,
   output logic [ADDR_W-1:0] wb_data,
   output logic [CYC_W-1:0]  extra_cyc,
   output logic [1:0]        bytes_used
);

   generate
      if (ADDR_W != 2 * BYTE_W) begin : g_bad_width
         $error("idx_ea_unit: ADDR_W must be twice BYTE_W");
      end
      if (BYTE_W < 5) begin : g_bad_byte
         $error("idx_ea_unit: BYTE_W must hold the 5-bit offset");
      end
      if (CYC_W < 4) begin : g_bad_cyc
         $error("idx_ea_unit: CYC_W must be at least 4");
      end
   endgenerate

   mode_t             mode;
   logic [ADDR_W-1:0] target;
   logic              upd_en;
   logic [ADDR_W-1:0] upd_val;
   logic              f_busy;
   logic [ADDR_W-1:0] f_word;
   logic              f_valid;
   logic              accept;
   logic              launch;

   logic              done_q;
   logic              legal_q;
   logic [ADDR_W-1:0] ea_q;
   logic              upd_q;
   logic [1:0]        sel_q;
   logic [ADDR_W-1:0] wbd_q;
   logic [CYC_W-1:0]  cyc_q;
   logic [1:0]        nby_q;

   idx_ea_mode_dec u_dec (
      .postbyte (postbyte),
      .mode     (mode)
   );

   idx_ea_addr_gen #(
      .ADDR_W (ADDR_W),
      .BYTE_W (BYTE_W)
   ) u_agen (
      .mode      (mode),
      .short_off (postbyte[4:0]),
      .reg_x     (reg_x),
      .reg_y     (reg_y),
      .reg_u     (reg_u),
      .reg_s     (reg_s),
      .acc_a     (acc_a),
      .acc_b     (acc_b),
      .pc_next   (pc_next),
      .ext_hi    (ext_hi),
      .ext_lo    (ext_lo),
      .target    (target),
      .upd_en    (upd_en),
      .upd_val   (upd_val)
   );

   assign accept = start && !f_busy;
   assign launch = accept && mode.indirect;

   idx_ea_ptr_fetch #(
      .ADDR_W (ADDR_W),
      .BYTE_W (BYTE_W)
   ) u_fetch (
      .clk         (clk),
      .rst_n       (rst_n),
      .go          (launch),
      .ptr         (target),
      .mem_rd_data (mem_rd_data),
      .busy        (f_busy),
      .mem_rd_en   (mem_rd_en),
      .mem_addr    (mem_addr),
      .word        (f_word),
      .word_valid  (f_valid)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q  <= 1'b0;
         legal_q <= 1'b0;
         ea_q    <= '0;
         upd_q   <= 1'b0;
         sel_q   <= 2'd0;
         wbd_q   <= '0;
         cyc_q   <= '0;
         nby_q   <= 2'd0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            legal_q <= mode.legal;
            upd_q   <= upd_en;
            sel_q   <= mode.base;
            wbd_q   <= upd_val;
            cyc_q   <= CYC_W'(mode.cycles);
            nby_q   <= mode.nbytes;
            if (!mode.indirect) begin
               ea_q   <= target;
               done_q <= 1'b1;
            end
         end else if (f_valid) begin
            ea_q   <= f_word;
            done_q <= 1'b1;
         end
      end
   end

   assign busy       = f_busy;
   assign done       = done_q;
   assign ea         = ea_q;
   assign wb_en      = done_q && upd_q;
   assign wb_sel     = sel_q;
   assign wb_data    = wbd_q;
   assign extra_cyc  = cyc_q;
   assign bytes_used = nby_q;

   // R12
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> !done);

   // R3
   wb_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> done);

   // R10
   undef_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !legal_q) |-> (ea == '0 && extra_cyc == '0 && !wb_en && bytes_used == 2'd0));

   // R11
   rd_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |-> (busy && !done));

   // R11
   ignore_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> ($stable(extra_cyc) && $stable(bytes_used) && $stable(wb_sel)));

endmodule

// File: tb/idx_ea_unit_tb.sv
module idx_ea_unit_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [7:0]  postbyte = 8'h00;
   logic [15:0] reg_x = 16'h1000;
   logic [15:0] reg_y = 16'h2000;
   logic [15:0] reg_u = 16'h3000;
   logic [15:0] reg_s = 16'h4000;
   logic [7:0]  acc_a = 8'h80;
   logic [7:0]  acc_b = 8'h05;
   logic [15:0] pc_next = 16'h8000;
   logic [7:0]  ext_hi = 8'hF0;
   logic [7:0]  ext_lo = 8'h10;
   logic        mem_rd_en;
   logic [15:0] mem_addr;
   logic [7:0]  mem_rd_data = 8'h00;
   logic        busy;
   logic        done;
   logic [15:0] ea;
   logic        wb_en;
   logic [1:0]  wb_sel;
   logic [15:0] wb_data;
   logic [3:0]  extra_cyc;
   logic [1:0]  bytes_used;

   int n_chk = 0;
   int n_fail = 0;
   int rd_cnt = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   idx_ea_unit u_dut (
      .clk (clk), .rst_n (rst_n), .start (start), .postbyte (postbyte),
      .reg_x (reg_x), .reg_y (reg_y), .reg_u (reg_u), .reg_s (reg_s),
      .acc_a (acc_a), .acc_b (acc_b), .pc_next (pc_next),
      .ext_hi (ext_hi), .ext_lo (ext_lo),
      .mem_rd_en (mem_rd_en), .mem_addr (mem_addr), .mem_rd_data (mem_rd_data),
      .busy (busy), .done (done), .ea (ea), .wb_en (wb_en), .wb_sel (wb_sel),
      .wb_data (wb_data), .extra_cyc (extra_cyc), .bytes_used (bytes_used)
   );

   function automatic logic [7:0] memf(input logic [15:0] a);
      return a[7:0] ^ a[15:8] ^ 8'h3C;
   endfunction

   function automatic logic [15:0] word_at(input logic [15:0] p);
      return {memf(p), memf(p + 16'd1)};
   endfunction

   always @(posedge clk) begin
      if (mem_rd_en) begin
         mem_rd_data <= memf(mem_addr);
         rd_cnt <= rd_cnt + 1;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic run_op(input logic [7:0] pb, input logic [15:0] e_ea,
                         input bit e_wb, input logic [1:0] e_sel, input logic [15:0] e_wbd,
                         input logic [3:0] e_cyc, input logic [1:0] e_by,
                         input int e_lat, input int e_reads, input string tag);
      int lat = 0;
      int r0;
      @(negedge clk);
      postbyte = pb;
      start = 1'b1;
      r0 = rd_cnt;
      do begin
         @(posedge clk);
         lat++;
         @(negedge clk);
         start = 1'b0;
      end while (!done && lat < 12);
      chk(lat == e_lat, {tag, " latency"}, lat, e_lat);
      chk(ea == e_ea, {tag, " ea"}, ea, e_ea);
      chk(wb_en == e_wb, {tag, " wb_en"}, wb_en, e_wb);
      if (e_wb) begin
         chk(wb_sel == e_sel, {tag, " wb_sel"}, wb_sel, e_sel);
         chk(wb_data == e_wbd, {tag, " wb_data"}, wb_data, e_wbd);
      end
      chk(extra_cyc == e_cyc, {tag, " cycles"}, extra_cyc, e_cyc);
      chk(bytes_used == e_by, {tag, " bytes"}, bytes_used, e_by);
      chk((rd_cnt - r0) == e_reads, {tag, " reads"}, rd_cnt - r0, e_reads);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(!done && !busy && !mem_rd_en && !wb_en, "R11 reset strobes", {done, busy, mem_rd_en, wb_en}, 0);
      chk(ea == 16'h0 && extra_cyc == 4'h0, "R12 reset outputs", ea, 0);
   endtask

   task automatic t_short();
      run_op(8'h05, 16'h1005, 0, 2'd0, 16'h0, 4'd1, 2'd0, 1, 0, "R2 X+5");
      run_op(8'h3F, 16'h1FFF, 0, 2'd1, 16'h0, 4'd1, 2'd0, 1, 0, "R1 R2 Y-1");
      run_op(8'h50, 16'h2FF0, 0, 2'd2, 16'h0, 4'd1, 2'd0, 1, 0, "R1 R2 U-16");
      run_op(8'h6F, 16'h400F, 0, 2'd3, 16'h0, 4'd1, 2'd0, 1, 0, "R1 R2 S+15");
   endtask

   task automatic t_autoinc();
      run_op(8'h80, 16'h1000, 1, 2'd0, 16'h1001, 4'd2, 2'd0, 1, 0, "R3 X+ R7");
      run_op(8'hA1, 16'h2000, 1, 2'd1, 16'h2002, 4'd3, 2'd0, 1, 0, "R3 Y++ R7");
      run_op(8'hC2, 16'h2FFF, 1, 2'd2, 16'h2FFF, 4'd2, 2'd0, 1, 0, "R3 -U R7");
      run_op(8'hE3, 16'h3FFE, 1, 2'd3, 16'h3FFE, 4'd3, 2'd0, 1, 0, "R3 --S R7");
   endtask

   task automatic t_acc();
      run_op(8'h85, 16'h1005, 0, 2'd0, 16'h0, 4'd1, 2'd0, 1, 0, "R4 X+B");
      run_op(8'h86, 16'h0F80, 0, 2'd0, 16'h0, 4'd1, 2'd0, 1, 0, "R4 X+A");
      run_op(8'h8B, 16'h9005, 0, 2'd0, 16'h0, 4'd4, 2'd0, 1, 0, "R4 X+D R7");
      run_op(8'hA4, 16'h2000, 0, 2'd1, 16'h0, 4'd0, 2'd0, 1, 0, "R4 ,Y R7");
   endtask

   task automatic t_const();
      run_op(8'h88, 16'h0FF0, 0, 2'd0, 16'h0, 4'd1, 2'd1, 1, 0, "R5 X+n8");
      run_op(8'h89, 16'h0010, 0, 2'd0, 16'h0, 4'd4, 2'd2, 1, 0, "R5 X+n16 R7");
   endtask

   task automatic t_pcrel();
      run_op(8'h8C, 16'h7FF1, 0, 2'd0, 16'h0, 4'd1, 2'd1, 1, 0, "R6 PC+n8");
      run_op(8'hEC, 16'h7FF1, 0, 2'd3, 16'h0, 4'd1, 2'd1, 1, 0, "R6 PC+n8 base ignored");
      run_op(8'h8D, 16'h7012, 0, 2'd0, 16'h0, 4'd5, 2'd2, 1, 0, "R6 PC+n16 R7");
   endtask

   task automatic t_indirect();
      run_op(8'h94, word_at(16'h1000), 0, 2'd0, 16'h0, 4'd3, 2'd0, 4, 2, "R8 [,X]");
      run_op(8'h99, word_at(16'h0010), 0, 2'd0, 16'h0, 4'd7, 2'd2, 4, 2, "R8 [X+n16]");
      run_op(8'hB1, word_at(16'h2000), 1, 2'd1, 16'h2002, 4'd6, 2'd0, 4, 2, "R8 R3 [,Y++]");
      run_op(8'hD3, word_at(16'h2FFE), 1, 2'd2, 16'h2FFE, 4'd6, 2'd0, 4, 2, "R8 R3 [,--U]");
      run_op(8'h9C, word_at(16'h7FF1), 0, 2'd0, 16'h0, 4'd4, 2'd1, 4, 2, "R8 R6 [PC+n8]");
      run_op(8'h9B, word_at(16'h9005), 0, 2'd0, 16'h0, 4'd7, 2'd0, 4, 2, "R8 R4 [X+D]");
   endtask

   task automatic t_absind();
      run_op(8'h9F, word_at(16'hF010), 0, 2'd0, 16'h0, 4'd5, 2'd2, 4, 2, "R9 [n16]");
   endtask

   task automatic t_undef();
      run_op(8'h87, 16'h0, 0, 2'd0, 16'h0, 4'd0, 2'd0, 1, 0, "R10 sub7");
      run_op(8'h8A, 16'h0, 0, 2'd0, 16'h0, 4'd0, 2'd0, 1, 0, "R10 sub10");
      run_op(8'h8E, 16'h0, 0, 2'd0, 16'h0, 4'd0, 2'd0, 1, 0, "R10 sub14");
      run_op(8'h8F, 16'h0, 0, 2'd0, 16'h0, 4'd0, 2'd0, 1, 0, "R10 direct sub15");
      run_op(8'h90, 16'h0, 0, 2'd0, 16'h0, 4'd0, 2'd0, 1, 0, "R10 indirect sub0");
      run_op(8'hB2, 16'h0, 0, 2'd1, 16'h0, 4'd0, 2'd0, 1, 0, "R10 indirect sub2");
   endtask

   task automatic t_busy_hold();
      int lat = 0;
      int extra_done = 0;
      @(negedge clk);
      postbyte = 8'h94;
      start = 1'b1;
      @(posedge clk);
      lat++;
      @(negedge clk);
      chk(busy == 1'b1, "R11 busy after accept", busy, 1);
      postbyte = 8'h05;
      do begin
         @(posedge clk);
         lat++;
         @(negedge clk);
         if (lat >= 3) start = 1'b0;
      end while (!done && lat < 12);
      start = 1'b0;
      chk(lat == 4, "R11 latency with ignored start", lat, 4);
      chk(ea == word_at(16'h1000), "R11 ignored start ea", ea, word_at(16'h1000));
      chk(extra_cyc == 4'd3, "R11 ignored start cycles", extra_cyc, 3);
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         if (done) extra_done++;
      end
      chk(extra_done == 0, "R12 done single pulse", extra_done, 0);
      chk(ea == word_at(16'h1000) && extra_cyc == 4'd3 && bytes_used == 2'd0,
          "R12 outputs held", ea, word_at(16'h1000));
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_short();
      t_autoinc();
      t_acc();
      t_const();
      t_pcrel();
      t_indirect();
      t_absind();
      t_undef();
      t_busy_hold();
      if (!finished) begin
         finished = 1'b1;
         $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
         $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule